// File: doc/BRIEF.md
# Serial-to-Memory Bus Bridge

This block is the serial slave port of a memory-mapped peripheral. A host selects it by pulling chip select low and then clocks in SPI mode 0 frames, most significant bit first. The first two bits of every frame pick the kind of transaction: a read or a write of a 22-bit byte address, or a three-byte host command. A read returns one dummy byte and then streams data bytes. A write accepts any number of data bytes. In both cases the address steps up by one per byte until chip select rises.

The serial pins are sampled in the system clock domain through two-stage synchronizers, so SCLK must be several system clocks per half period. On the bus side the bridge issues single-cycle write strobes and read requests. Read data is taken one clock after the request. Each read byte is fetched during the byte before it, so the data is ready before its first bit leaves on MISO. Commands leave as a 6-bit code with a one-cycle valid strobe. A read frame aimed at address 0 also raises a wake strobe that the power controller treats as the activate command.

Top module: `spi_mem_bridge`

## Requirements
- R1: Serial data is sampled on rising SCLK edges while CS_N is low, most significant bit first; eight bits form one byte, and the bits of a byte left incomplete when CS_N rises are dropped.
- R2: A first byte whose bits [7:6] are 10 starts a write; its bits [5:0] and the next two bytes form address bits [21:16], [15:8], [7:0]; every later byte gives one wr_o pulse with that byte on wdata_o and the current address on addr_o.
- R3: A first byte whose bits [7:6] are 00 starts a read with the same address layout; the fourth byte is a dummy that reads back 00h on MISO, and every later byte shifts out, MSB first, the memory byte at the current address.
- R4: Each read byte is requested with a one-cycle rd_req_o during the byte before it (the dummy byte for the first). rd_data_i is taken in the cycle after rd_req_o.
- R5: A first byte whose bits [7:6] are 01 is a command; cmd_code_o carries its bits [5:0] and cmd_valid_o pulses for one cycle once the third byte of the frame completes.
- R6: A command frame in which CS_N rises before the third byte completes produces no cmd_valid_o pulse.
- R7: A frame whose first byte has bits [7:6] equal to 11 produces no write, read request, command or wake pulse.
- R8: A read frame whose 22-bit address is zero raises wake_o for one cycle after its third byte; reads of any other address do not.
- R9: The address increases by one after each data byte and wraps from 3FFFFFh to 000000h.
- R10: CS_N rising ends the frame; the next falling edge restarts prefix decoding from the first byte.
- R11: After reset and while CS_N is high, miso_o is 0, and wr_o, rd_req_o, cmd_valid_o and wake_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| addr_o | output | 22 | Bus byte address |
| wdata_o | output | 8 | Bus write data |
| wr_o | output | 1 | Write strobe, one cycle |
| rd_req_o | output | 1 | Read request, one cycle |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_req_o |
| cmd_code_o | output | 6 | Host command code |
| cmd_valid_o | output | 1 | Command strobe, one cycle |
| wake_o | output | 1 | Wake strobe from a read of address 0 |

## Verification
A rising SCLK edge reaches the byte counter three system clocks after it occurs. A write strobe, command strobe or wake strobe then follows one clock after the byte completes, and a read request one clock after the fourth bit of the preceding byte. The bench holds each SCLK phase for four system clocks and logs every strobe at falling clock edges. It compares the logs with expected values only after CS_N has been high for eight clocks. MISO is sampled just before each rising SCLK edge, which is where a mode-0 host would latch it.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  typedef enum logic [1:0] {
    PFX_READ  = 2'b00,
    PFX_CMD   = 2'b01,
    PFX_WRITE = 2'b10,
    PFX_BAD   = 2'b11
  } pfx_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              mid_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W-1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(BYTE_W/2-1);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              take;

  assign take = active_i & sclk_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      byte_done_o <= 1'b0;
      byte_o      <= '0;
      mid_o       <= 1'b0;
    end else begin
      byte_done_o <= take && (bit_cnt_q == LAST);
      mid_o       <= take && (bit_cnt_q == HALF);
      if (!active_i) begin
        bit_cnt_q <= '0;
      end else if (sclk_rise_i) begin
        sh_q      <= {sh_q[BYTE_W-3:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST) byte_o <= {sh_q, mosi_i};
      end
    end
  end

  // outgoing byte, replaced at each byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= '0;
    else if (!active_i) tx_q <= '0;
    else if (tx_load_i) tx_q <= tx_byte_i;
  end

  assign miso_o = active_i & tx_q[LAST - bit_cnt_q];
endmodule

// File: rtl/spi_txn_fsm.sv
module spi_txn_fsm
  import spi_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              mid_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_req_o,
  output logic [BYTE_W-3:0] cmd_code_o,
  output logic              cmd_valid_o,
  output logic              wake_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  localparam int unsigned HI_W = ADDR_W - 2*BYTE_W;
  localparam logic [2:0] IDX_A1   = 3'd1;
  localparam logic [2:0] IDX_A2   = 3'd2;
  localparam logic [2:0] IDX_DATA = 3'd3;
  localparam logic [2:0] IDX_MAX  = 3'd4;

  logic [2:0]        idx_q;
  pfx_e              pfx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_pend_q;
  logic [BYTE_W-1:0] next_q;
  logic              in_data;

  assign in_data = (idx_q >= IDX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      pfx_q       <= PFX_BAD;
      addr_q      <= '0;
      addr_o      <= '0;
      wdata_o     <= '0;
      wr_o        <= 1'b0;
      rd_req_o    <= 1'b0;
      cmd_code_o  <= '0;
      cmd_valid_o <= 1'b0;
      wake_o      <= 1'b0;
      rd_pend_q   <= 1'b0;
      next_q      <= '0;
    end else begin
      wr_o        <= 1'b0;
      rd_req_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      wake_o      <= 1'b0;
      rd_pend_q   <= rd_req_o;
      if (rd_pend_q) next_q <= rd_data_i;
      if (!active_i) begin
        idx_q <= '0;
      end else if (byte_done_i) begin
        if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
        if (idx_q == '0) begin
          pfx_q <= pfx_e'(byte_i[BYTE_W-1 -: 2]);
          addr_q[ADDR_W-1:2*BYTE_W] <= byte_i[HI_W-1:0];
          if (pfx_e'(byte_i[BYTE_W-1 -: 2]) == PFX_CMD) cmd_code_o <= byte_i[BYTE_W-3:0];
        end else if (idx_q == IDX_A1) begin
          addr_q[2*BYTE_W-1:BYTE_W] <= byte_i;
        end else if (idx_q == IDX_A2) begin
          addr_q[BYTE_W-1:0] <= byte_i;
          if (pfx_q == PFX_READ && {addr_q[ADDR_W-1:BYTE_W], byte_i} == '0) wake_o <= 1'b1;
          if (pfx_q == PFX_CMD) cmd_valid_o <= 1'b1;
        end else if (pfx_q == PFX_WRITE) begin
          wr_o    <= 1'b1;
          wdata_o <= byte_i;
          addr_o  <= addr_q;
          addr_q  <= addr_q + 1'b1;
        end
      end else if (mid_i && in_data && pfx_q == PFX_READ) begin
        // fetch the byte that goes out after this one
        rd_req_o <= 1'b1;
        addr_o   <= addr_q;
        addr_q   <= addr_q + 1'b1;
      end
    end
  end

  assign tx_load_o = byte_done_i;
  assign tx_byte_o = (in_data && pfx_q == PFX_READ) ? next_q : '0;
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-3:0] cmd_code_o,
  output logic              cmd_valid_o,
  output logic              wake_o
);
  logic [2:0]        pins_s;
  logic              sclk_q;
  logic              active;
  logic              sclk_rise;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_rx;
  logic              mid;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_byte;

  // {cs_n, sclk, mosi}
  spi_in_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= pins_s[1];
  end

  assign active    = ~pins_s[2];
  assign sclk_rise = pins_s[1] & ~sclk_q;

  spi_shifter #(.BYTE_W(BYTE_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .sclk_rise_i(sclk_rise),
    .mosi_i     (pins_s[0]),
    .tx_load_i  (tx_load),
    .tx_byte_i  (tx_byte),
    .byte_done_o(byte_done),
    .byte_o     (byte_rx),
    .mid_o      (mid),
    .miso_o     (miso_o)
  );

  spi_txn_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .byte_done_i(byte_done),
    .byte_i     (byte_rx),
    .mid_i      (mid),
    .rd_data_i  (rd_data_i),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .wr_o       (wr_o),
    .rd_req_o   (rd_req_o),
    .cmd_code_o (cmd_code_o),
    .cmd_valid_o(cmd_valid_o),
    .wake_o     (wake_o),
    .tx_load_o  (tx_load),
    .tx_byte_o  (tx_byte)
  );
endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wr_o,
  input logic              rd_req_o,
  input logic              cmd_valid_o,
  input logic              wake_o
);
  logic [1:0]        idle_cnt_q;
  logic              have_wr_q;
  logic [ADDR_W-1:0] last_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      have_wr_q  <= 1'b0;
      last_wr_q  <= '0;
    end else begin
      if (!cs_ni) idle_cnt_q <= '0;
      else if (idle_cnt_q != 2'd3) idle_cnt_q <= idle_cnt_q + 1'b1;
      if (cs_ni && idle_cnt_q == 2'd3) have_wr_q <= 1'b0;
      else if (wr_o) begin
        have_wr_q <= 1'b1;
        last_wr_q <= addr_o;
      end
    end
  end

  p_bus_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_req_o));
  p_wr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  p_wr_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && have_wr_q) |-> (addr_o == last_wr_q + 1'b1));
  p_rd_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_cmd_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_wake_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_miso_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt_q == 2'd3) |-> !miso_o);
endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .miso_o     (miso_o),
  .addr_o     (addr_o),
  .wr_o       (wr_o),
  .rd_req_o   (rd_req_o),
  .cmd_valid_o(cmd_valid_o),
  .wake_o     (wake_o)
);

// File: tb/test_spi_mem_bridge.sv
`timescale 1ns/1ps
module test_spi_mem_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [21:0] addr;
  logic [7:0] wdata, rd_data;
  logic wr, rd_req, cmd_valid, wake;
  logic [5:0] cmd_code;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [64];
  logic [21:0] wr_addr_log [16];
  logic [7:0]  wr_data_log [16];
  logic [21:0] rd_addr_log [16];
  int n_wr, n_rd, n_cmd, n_wake;
  logic [5:0] last_code;
  bit done = 0;

  always #4 clk = ~clk;

  spi_mem_bridge i_spi_mem_bridge (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .addr_o(addr), .wdata_o(wdata), .wr_o(wr), .rd_req_o(rd_req),
    .rd_data_i(rd_data), .cmd_code_o(cmd_code), .cmd_valid_o(cmd_valid), .wake_o(wake)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) if (rd_req) rd_data <= mem[addr[5:0]];

  always @(negedge clk) begin
    if (wr && n_wr < 16) begin wr_addr_log[n_wr] = addr; wr_data_log[n_wr] = wdata; end
    if (wr) n_wr++;
    if (rd_req && n_rd < 16) rd_addr_log[n_rd] = addr;
    if (rd_req) n_rd++;
    if (cmd_valid) begin n_cmd++; last_code = cmd_code; end
    if (wake) n_wake++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_wr = 0; n_rd = 0; n_cmd = 0; n_wake = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      repeat (4) @(negedge clk);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic start_txn();
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_txn();
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(miso == 1'b0, "R11 reset miso", miso, 0);
    chk(!wr && !rd_req && !cmd_valid && !wake, "R11 reset strobes",
        {wr, rd_req, cmd_valid, wake}, 0);
  endtask

  task automatic t_write_burst();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h81, 8, rx); xfer(8'h23, 8, rx); xfer(8'h45, 8, rx);
    xfer(8'hA5, 8, rx); xfer(8'h3C, 8, rx); xfer(8'h0F, 8, rx);
    end_txn();
    chk(n_wr == 3, "R2 write count", n_wr, 3);
    chk(wr_addr_log[0] == 22'h012345 && wr_data_log[0] == 8'hA5, "R1 R2 first write",
        {wr_addr_log[0], wr_data_log[0]}, {22'h012345, 8'hA5});
    chk(wr_addr_log[2] == 22'h012347 && wr_data_log[2] == 8'h0F, "R2 R9 third write",
        {wr_addr_log[2], wr_data_log[2]}, {22'h012347, 8'h0F});
  endtask

  task automatic t_read_burst();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h00, 8, rx); xfer(8'h00, 8, rx); xfer(8'h10, 8, rx);
    xfer(8'hFF, 8, rx);
    chk(rx == 8'h00, "R3 dummy byte", rx, 0);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 8, rx);
      chk(rx == mem[16+k], "R3 read data", rx, mem[16+k]);
    end
    end_txn();
    chk(n_rd == 4, "R4 request count", n_rd, 4);
    chk(rd_addr_log[0] == 22'h10 && rd_addr_log[3] == 22'h13, "R4 request addresses",
        {rd_addr_log[0], rd_addr_log[3]}, {22'h10, 22'h13});
    chk(n_wake == 0, "R8 no wake nonzero", n_wake, 0);
  endtask

  task automatic t_wake();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h00, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 8, rx);
    xfer(8'h00, 8, rx); xfer(8'h00, 8, rx);
    end_txn();
    chk(n_wake == 1, "R8 wake pulse", n_wake, 1);
    chk(rx == mem[0], "R3 R8 read addr 0", rx, mem[0]);
  endtask

  task automatic t_command();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h62, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 8, rx);
    end_txn();
    chk(n_cmd == 1, "R5 command strobe", n_cmd, 1);
    chk(last_code == 6'h22, "R5 command code", last_code, 6'h22);
    chk(n_wr == 0 && n_rd == 0, "R5 no bus access", n_wr + n_rd, 0);
  endtask

  task automatic t_cmd_short();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h48, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 5, rx);
    end_txn();
    chk(n_cmd == 0, "R6 short command dropped", n_cmd, 0);
  endtask

  task automatic t_bad_prefix();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'hC1, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 8, rx);
    xfer(8'h55, 8, rx); xfer(8'h66, 8, rx);
    end_txn();
    chk(n_wr == 0 && n_rd == 0 && n_cmd == 0 && n_wake == 0, "R7 prefix 11 ignored",
        n_wr + n_rd + n_cmd + n_wake, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'hBF, 8, rx); xfer(8'hFF, 8, rx); xfer(8'hFF, 8, rx);
    xfer(8'h11, 8, rx); xfer(8'h22, 8, rx);
    end_txn();
    chk(n_wr == 2, "R9 wrap write count", n_wr, 2);
    chk(wr_addr_log[0] == 22'h3FFFFF, "R9 top address", wr_addr_log[0], 22'h3FFFFF);
    chk(wr_addr_log[1] == 22'h000000 && wr_data_log[1] == 8'h22, "R9 wrapped address",
        {wr_addr_log[1], wr_data_log[1]}, {22'h0, 8'h22});
  endtask

  task automatic t_partial();
    logic [7:0] rx;
    clear_logs();
    start_txn();
    xfer(8'h80, 8, rx); xfer(8'h00, 8, rx); xfer(8'h20, 8, rx);
    xfer(8'h77, 8, rx); xfer(8'hEE, 4, rx);
    end_txn();
    chk(n_wr == 1, "R1 R10 partial byte dropped", n_wr, 1);
    // next frame must decode its own prefix
    start_txn();
    xfer(8'h63, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 8, rx);
    end_txn();
    chk(n_cmd == 1 && last_code == 6'h23, "R10 new frame decoded", last_code, 6'h23);
    chk(miso == 1'b0, "R11 miso idle", miso, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    rd_data = '0;
    clear_logs();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wake();
    t_command();
    t_cmd_short();
    t_bad_prefix();
    t_wrap();
    t_partial();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule